// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and Completion Interface

This block is the processor-facing side of an interrupt controller, for a single CPU. Software reaches it through a small word-addressed register window. Through that window it enables the interface, sets a priority mask, acknowledges the highest pending interrupt, signals end of interrupt, and reads back the running priority and the highest pending ID. An external selection engine supplies the highest pending ID and its priority. The interface supplies the running priority, the mask and the enable back to that engine.

On each successful acknowledge, the interface records the ID that was running before. It keeps that record in a per-interrupt link table, along with the priority snapshot of that ID. The active interrupts therefore form a chain, from the running one down to the idle marker 1023. Completing the running interrupt pops the chain. Completing a buried interrupt starts a small walker that follows one link per clock and splices the entry out. While the walker runs, the register port is not ready.

Toward the distributor state the block issues two strobes, each one cycle after the access that caused it. A pending-clear strobe follows a successful acknowledge and says whether the clear applies to all CPUs or only this one. A pending-set strobe follows a completion when the distributor reports that the interrupt is level-triggered, enabled, still asserted and targeted at this CPU.

Top module: `irq_cpu_iface`

## Requirements
- R1: Byte offsets: 0x00 control (bit 0 = interface enable), 0x04 priority mask (bits 7:0), 0x08 binary point, 0x0C acknowledge (read), 0x10 end of interrupt (write, ID in bits 9:0), 0x14 running priority, 0x18 highest pending ID. After reset the enable reads 0 and the mask reads 0xF0. Writes to control and mask read back with only their defined bits kept.
- R2: An acknowledge read returns 1023 and changes no state when the highest pending ID is 1023, or when its priority is not strictly below the running priority.
- R3: A successful acknowledge returns the pending ID. That ID becomes running, and the running priority becomes its priority. In the next cycle `pend_clr` pulses with that ID, and `pend_clr_all` equals the model input (1 = clear for all CPUs).
- R4: After reset, and whenever no interrupt is running, the running priority reads 0x100.
- R5: Completing the running interrupt makes the interrupt that it preempted running again, with that interrupt's priority restored. Completing the last one returns the running priority to 0x100.
- R6: An end-of-interrupt write while no interrupt is running has no effect: there is no strobe and the running priority is unchanged.
- R7: On an accepted completion while an interrupt is running, `pend_set` pulses in the next cycle with the written ID. It pulses only if `eoi_edge`=0, `eoi_en`=1, `eoi_level`=1 and `eoi_tgt`=1.
- R8: Completing an active interrupt that is not the running one removes it from the chain. The running priority does not change, and later completions unwind past it.
- R9: A completion that is not the running ID drops `req_ready` in the following cycle while the chain is walked, one link per clock. An ID absent from the chain leaves the chain unchanged.
- R10: The binary point reads 0 and ignores writes. Offset 0x18 returns the `hp_id` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access accepted when high together with req_valid |
| rsp_rdata | output | 32 | Read data, valid in the cycle of the accepted read |
| hp_id | input | 10 | Highest pending ID from the selection engine |
| hp_prio | input | 8 | Priority of hp_id |
| hp_model | input | 1 | Model bit of hp_id (1 = clear for all CPUs) |
| eoi_lookup_id | output | 10 | ID on the write bus, for attribute lookup |
| eoi_edge | input | 1 | Looked-up ID is edge-triggered |
| eoi_en | input | 1 | Looked-up ID is enabled |
| eoi_level | input | 1 | Looked-up ID line is asserted |
| eoi_tgt | input | 1 | This CPU is in the looked-up ID's target mask |
| cpu_en | output | 1 | Interface enable |
| prio_mask | output | 8 | Priority mask |
| run_prio | output | 9 | Running priority (0x100 = idle) |
| pend_clr | output | 1 | Pending-clear strobe |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_all | output | 1 | Clear for all CPUs |
| pend_set | output | 1 | Pending-set strobe for this CPU |
| pend_set_id | output | 10 | ID to set pending |

## Verification
The hardest state to reach is a completion that hits an entry buried in a nested chain. The ports expose only the running priority, so the walker's splice can be seen only through the priorities that later completions restore. The stimulus builds a three-deep chain with distinct priorities. It then completes the three IDs in all six orders and compares each restored running priority against an ordered-list model in the bench. The repend gating is swept over all sixteen attribute combinations. The acknowledge threshold is swept over every priority value against a fixed running priority.

// File: rtl/irq_cpu_iface_pkg.sv
package irq_cpu_iface_pkg;

    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = PRIO_W + 1;

    localparam logic [ID_W-1:0]    IDLE_ID    = 10'd1023;
    localparam logic [RPRIO_W-1:0] RPRIO_IDLE = 9'h100;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CTRL,
        OP_PMASK,
        OP_BPR,
        OP_ACK,
        OP_EOI,
        OP_RPRIO,
        OP_HPID
    } op_e;

    // one entry of the per-interrupt chain table
    typedef struct packed {
        logic [ID_W-1:0]    prev_id;
        logic [RPRIO_W-1:0] prev_prio;
    } link_t;

    typedef struct packed {
        logic               cpu_en;
        logic [PRIO_W-1:0]  pmask;
        logic [ID_W-1:0]    run_id;
        logic [RPRIO_W-1:0] run_prio;
        logic               walking;
        logic [ID_W-1:0]    cursor;
        logic [ID_W-1:0]    target;
        logic               clr_v;
        logic [ID_W-1:0]    clr_id;
        logic               clr_all;
        logic               set_v;
        logic [ID_W-1:0]    set_id;
    } state_t;

endpackage

// File: rtl/irq_cpu_iface_decode.sv
module irq_cpu_iface_decode
    import irq_cpu_iface_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output op_e               op
);
    localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_PMASK = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFF_BPR   = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFF_ACK   = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] OFF_EOI   = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] OFF_RPRIO = ADDR_W'(8'h14);
    localparam logic [ADDR_W-1:0] OFF_HPID  = ADDR_W'(8'h18);

    always_comb begin
        op = OP_NONE;
        if (addr == OFF_CTRL)       op = OP_CTRL;
        else if (addr == OFF_PMASK) op = OP_PMASK;
        else if (addr == OFF_BPR)   op = OP_BPR;
        else if (addr == OFF_ACK)   op = OP_ACK;
        else if (addr == OFF_EOI)   op = OP_EOI;
        else if (addr == OFF_RPRIO) op = OP_RPRIO;
        else if (addr == OFF_HPID)  op = OP_HPID;
    end
endmodule

// File: rtl/irq_cpu_iface_eval.sv
module irq_cpu_iface_eval
    import irq_cpu_iface_pkg::*;
#(
    parameter int NIRQ = 64
) (
    input  logic [ID_W-1:0]    hp_id,
    input  logic [PRIO_W-1:0]  hp_prio,
    input  logic [RPRIO_W-1:0] run_prio,
    input  logic               eoi_edge,
    input  logic               eoi_en,
    input  logic               eoi_level,
    input  logic               eoi_tgt,
    output logic               ack_ok,
    output logic               repend
);
    localparam logic [ID_W-1:0] NIRQ_ID = ID_W'(NIRQ);

    always_comb begin
        ack_ok = (hp_id != IDLE_ID) && (hp_id < NIRQ_ID) &&
                 ({1'b0, hp_prio} < run_prio);
        repend = !eoi_edge && eoi_en && eoi_level && eoi_tgt;
    end
endmodule

// File: rtl/irq_cpu_iface.sv
module irq_cpu_iface
    import irq_cpu_iface_pkg::*;
#(
    parameter int NIRQ   = 64,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [9:0]        hp_id,
    input  logic [7:0]        hp_prio,
    input  logic              hp_model,
    output logic [9:0]        eoi_lookup_id,
    input  logic              eoi_edge,
    input  logic              eoi_en,
    input  logic              eoi_level,
    input  logic              eoi_tgt,
    output logic              cpu_en,
    output logic [7:0]        prio_mask,
    output logic [8:0]        run_prio,
    output logic              pend_clr,
    output logic [9:0]        pend_clr_id,
    output logic              pend_clr_all,
    output logic              pend_set,
    output logic [9:0]        pend_set_id
);
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    state_t s_q, s_d;
    link_t  link_q [NIRQ];
    link_t  link_d [NIRQ];

    op_e             op;
    logic            ack_ok;
    logic            repend;
    logic            acc;
    logic [ID_W-1:0] wr_id;
    logic [ID_W-1:0] walk_nxt;

    irq_cpu_iface_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .op   (op)
    );

    irq_cpu_iface_eval #(.NIRQ(NIRQ)) u_eval (
        .hp_id     (hp_id),
        .hp_prio   (hp_prio),
        .run_prio  (s_q.run_prio),
        .eoi_edge  (eoi_edge),
        .eoi_en    (eoi_en),
        .eoi_level (eoi_level),
        .eoi_tgt   (eoi_tgt),
        .ack_ok    (ack_ok),
        .repend    (repend)
    );

    assign acc      = req_valid && !s_q.walking;
    assign wr_id    = req_wdata[ID_W-1:0];
    assign walk_nxt = link_q[s_q.cursor[IDX_W-1:0]].prev_id;

    always_comb begin
        s_d       = s_q;
        link_d    = link_q;
        s_d.clr_v = 1'b0;
        s_d.set_v = 1'b0;
        rsp_rdata = '0;

        case (op)
            OP_CTRL:  rsp_rdata = DATA_W'(s_q.cpu_en);
            OP_PMASK: rsp_rdata = DATA_W'(s_q.pmask);
            OP_ACK:   rsp_rdata = DATA_W'(ack_ok ? hp_id : IDLE_ID);
            OP_RPRIO: rsp_rdata = DATA_W'(s_q.run_prio);
            OP_HPID:  rsp_rdata = DATA_W'(hp_id);
            default:  rsp_rdata = '0;
        endcase

        if (acc && req_write) begin
            case (op)
                OP_CTRL:  s_d.cpu_en = req_wdata[0];
                OP_PMASK: s_d.pmask  = req_wdata[PRIO_W-1:0];
                OP_EOI: begin
                    if (s_q.run_id != IDLE_ID) begin
                        s_d.set_v  = repend;
                        s_d.set_id = wr_id;
                        if (wr_id == s_q.run_id) begin
                            s_d.run_id   = link_q[s_q.run_id[IDX_W-1:0]].prev_id;
                            s_d.run_prio = link_q[s_q.run_id[IDX_W-1:0]].prev_prio;
                        end else begin
                            s_d.walking = 1'b1;
                            s_d.cursor  = s_q.run_id;
                            s_d.target  = wr_id;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (acc && !req_write && op == OP_ACK && ack_ok) begin
            link_d[hp_id[IDX_W-1:0]] = '{prev_id: s_q.run_id, prev_prio: s_q.run_prio};
            s_d.run_id   = hp_id;
            s_d.run_prio = {1'b0, hp_prio};
            s_d.clr_v    = 1'b1;
            s_d.clr_id   = hp_id;
            s_d.clr_all  = hp_model;
        end

        // chain walker: one link per clock
        if (s_q.walking) begin
            if (walk_nxt == IDLE_ID) begin
                s_d.walking = 1'b0;
            end else if (walk_nxt == s_q.target) begin
                link_d[s_q.cursor[IDX_W-1:0]] = link_q[walk_nxt[IDX_W-1:0]];
                s_d.walking = 1'b0;
            end else begin
                s_d.cursor = walk_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.pmask    <= 8'hF0;
            s_q.run_id   <= IDLE_ID;
            s_q.run_prio <= RPRIO_IDLE;
            s_q.cursor   <= IDLE_ID;
            s_q.target   <= IDLE_ID;
            for (int i = 0; i < NIRQ; i++) begin
                link_q[i] <= '{prev_id: IDLE_ID, prev_prio: RPRIO_IDLE};
            end
        end else begin
            s_q <= s_d;
            for (int i = 0; i < NIRQ; i++) begin
                link_q[i] <= link_d[i];
            end
        end
    end

    assign req_ready     = !s_q.walking;
    assign eoi_lookup_id = wr_id;
    assign cpu_en        = s_q.cpu_en;
    assign prio_mask     = s_q.pmask;
    assign run_prio      = s_q.run_prio;
    assign pend_clr      = s_q.clr_v;
    assign pend_clr_id   = s_q.clr_id;
    assign pend_clr_all  = s_q.clr_all;
    assign pend_set      = s_q.set_v;
    assign pend_set_id   = s_q.set_id;

    // R4
    idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run_id == IDLE_ID) |-> (s_q.run_prio == RPRIO_IDLE));

    // R3
    ack_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.clr_v |-> (s_q.run_id == s_q.clr_id));

    // R3
    ack_prio_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && op == OP_ACK && ack_ok) |=> (s_q.run_prio < $past(s_q.run_prio)));

    // R2
    ack_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && op == OP_ACK && rsp_rdata == DATA_W'(IDLE_ID))
        |=> ($stable(s_q.run_id) && !s_q.clr_v));

    // R6
    eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && op == OP_EOI && s_q.run_id == IDLE_ID)
        |=> (!s_q.set_v && s_q.run_id == IDLE_ID));

    // R9
    walk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.walking |=> (!s_q.clr_v && !s_q.set_v && $stable(s_q.run_id)));
endmodule

// File: tb/irq_cpu_iface_tb.sv
`timescale 1ns/100ps
module irq_cpu_iface_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic [9:0]  hp_id = 10'd1023;
    logic [7:0]  hp_prio = '0;
    logic        hp_model = 1'b0;
    logic [9:0]  eoi_lookup_id;
    logic        eoi_edge = 1'b0, eoi_en = 1'b0, eoi_level = 1'b0, eoi_tgt = 1'b0;
    logic        cpu_en;
    logic [7:0]  prio_mask;
    logic [8:0]  run_prio;
    logic        pend_clr, pend_clr_all, pend_set;
    logic [9:0]  pend_clr_id, pend_set_id;

    int total = 0;
    int bad   = 0;
    int mod_id [$];
    int mod_pr [$];

    irq_cpu_iface u_dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, capture read data before the edge, return at the following negedge
    task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1 rd = rsp_rdata;
        @(posedge clk);
        #0.5 req_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic int exp_rprio();
        return (mod_id.size() == 0) ? 32'h100 : mod_pr[mod_pr.size()-1];
    endfunction

    task automatic do_ack(input int id, input int pr, input bit model);
        logic [31:0] rd;
        hp_id = 10'(id); hp_prio = 8'(pr); hp_model = model;
        xfer(1'b0, 8'h0C, 0, rd);
        check("R3 ack id", rd, id);
        check("R3 clr strobe", {pend_clr, pend_clr_all, pend_clr_id}, {1'b1, model, 10'(id)});
        mod_id.push_back(id); mod_pr.push_back(pr);
        check("R3 run prio", run_prio, exp_rprio());
    endtask

    task automatic do_eoi(input int id);
        logic [31:0] rd;
        bit buried;
        buried = (mod_id.size() > 1) && (mod_id[mod_id.size()-1] != id);
        xfer(1'b1, 8'h10, id, rd);
        if (buried) check("R9 ready low", req_ready, 0);
        for (int i = 0; i < mod_id.size(); i++) begin
            if (mod_id[i] == id) begin
                mod_id.delete(i); mod_pr.delete(i);
                break;
            end
        end
        while (!req_ready) @(negedge clk);
        xfer(1'b0, 8'h14, 0, rd);
        check(buried ? "R8 splice rprio" : "R5 unwind rprio", rd, exp_rprio());
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] rd;
        int ids [3] = '{4, 17, 40};
        int prs [3] = '{'h90, 'h50, 'h18};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4 reset state
        xfer(1'b0, 8'h00, 0, rd); check("R1 ctrl reset", rd, 0);
        xfer(1'b0, 8'h04, 0, rd); check("R1 mask reset", rd, 'hF0);
        xfer(1'b0, 8'h14, 0, rd); check("R4 rprio reset", rd, 'h100);
        hp_id = 10'd1023; hp_prio = 8'h00;
        xfer(1'b0, 8'h0C, 0, rd); check("R2 ack none", rd, 1023);
        check("R2 no clr", pend_clr, 0);

        // R1 register readback
        xfer(1'b1, 8'h00, 32'hFFFF_FFFF, rd);
        xfer(1'b0, 8'h00, 0, rd); check("R1 ctrl", rd, 1);
        check("R1 cpu_en pin", cpu_en, 1);
        xfer(1'b1, 8'h04, 32'h0000_01AB, rd);
        xfer(1'b0, 8'h04, 0, rd); check("R1 mask", rd, 'hAB);
        check("R1 mask pin", prio_mask, 'hAB);

        // R10 binary point, highest pending, unmapped
        xfer(1'b1, 8'h08, 32'h7, rd);
        xfer(1'b0, 8'h08, 0, rd); check("R10 bpr", rd, 0);
        hp_id = 10'd321;
        xfer(1'b0, 8'h18, 0, rd); check("R10 hp id", rd, 321);
        xfer(1'b0, 8'h1C, 0, rd); check("R10 unmapped", rd, 0);

        // R6 completion while idle
        eoi_edge = 0; eoi_en = 1; eoi_level = 1; eoi_tgt = 1;
        xfer(1'b1, 8'h10, 12, rd);
        check("R6 no set", pend_set, 0);
        check("R6 rprio", run_prio, 'h100);

        // R2 threshold sweep against running priority 0x40
        do_ack(30, 'h40, 1'b0);
        for (int p = 0; p < 256; p++) begin
            hp_id = 10'd31; hp_prio = 8'(p); hp_model = 1'b1;
            xfer(1'b0, 8'h0C, 0, rd);
            if (p < 'h40) begin
                check("R3 sweep grant", rd, 31);
                check("R3 sweep clr", {pend_clr, pend_clr_all}, 2'b11);
                xfer(1'b1, 8'h10, 31, rd);
            end else begin
                check("R2 sweep deny", rd, 1023);
                check("R2 sweep no clr", pend_clr, 0);
            end
            check("R2 sweep rprio", run_prio, 'h40);
        end
        hp_id = 10'd1023; hp_prio = 8'h00;
        xfer(1'b0, 8'h0C, 0, rd); check("R2 id idle deny", rd, 1023);
        mod_id.delete(); mod_pr.delete();
        xfer(1'b1, 8'h10, 30, rd);
        check("R5 back idle", run_prio, 'h100);

        // R7 repend gating sweep, R3 model passthrough
        for (int c = 0; c < 16; c++) begin
            eoi_edge = 0; eoi_en = 0; eoi_level = 0; eoi_tgt = 0;
            do_ack(12, 'h30, c[0]);
            {eoi_edge, eoi_en, eoi_level, eoi_tgt} = 4'(c);
            xfer(1'b1, 8'h10, 12, rd);
            mod_id.delete(); mod_pr.delete();
            check("R7 set strobe", {pend_set, pend_set_id}, {(c == 7) ? 1'b1 : 1'b0, 10'd12});
            check("R5 rprio after", run_prio, 'h100);
        end
        eoi_edge = 0; eoi_en = 0; eoi_level = 0; eoi_tgt = 0;

        // R9 completion of an ID not in the chain
        do_ack(7, 'h20, 1'b0);
        xfer(1'b1, 8'h10, 50, rd);
        while (!req_ready) @(negedge clk);
        xfer(1'b0, 8'h14, 0, rd); check("R9 absent no change", rd, 'h20);
        do_eoi(7);

        // R5 / R8 / R9 all completion orders of a three-deep chain
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                if (a == b) continue;
                do_ack(ids[0], prs[0], 1'b0);
                do_ack(ids[1], prs[1], 1'b1);
                do_ack(ids[2], prs[2], 1'b0);
                do_eoi(ids[a]);
                do_eoi(ids[b]);
                do_eoi(ids[3 - a - b]);
                check("R4 idle after order", run_prio, 'h100);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule